// File: doc/BRIEF.md
# Floating-Point Register Tag Tracker

This block holds one occupancy bit per register for a stack of eight 80-bit floating-point registers. A register is either empty or full. Dedicated strobes mark single registers full or empty. An initialise command empties every register at once. A packed-media write fills every register at once. A restore command loads occupancy from a saved 16-bit tag word.

Software wants a 2-bit code per register, not a single bit. The block builds that code when it is read. It looks at the occupancy bit and at the live contents of each register, which come in from the register file. It reports each register as empty, valid, zero or special. The register file and the stack-top rotation sit outside this block.

Top module: `fp_tag_tracker`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every register is empty and `tag_word` reads 16'hFFFF.
- R2: Register i's code sits in `tag_word[2i+1:2i]`, so register 7 sits in bits 15:14 and register 0 in bits 1:0. The codes are 00 valid, 01 zero, 10 special and 11 empty.
- R3: An empty register reads 11 whatever its contents are.
- R4: Each register value has the sign in bit 79, the exponent in bits 78:64 and the 64-bit significand in bits 63:0. The explicit integer bit is bit 63. A full register with a zero exponent and a zero significand reads 01.
- R5: A full register reads 10 when its exponent is all ones (NaN or infinity). It also reads 10 when its exponent is zero and its significand is nonzero (denormal).
- R6: A full register with an exponent that is neither zero nor all ones reads 10 when bit 63 is clear (unsupported). It reads 00 when bit 63 is set.
- R7: `init_all` empties all registers at the next clock edge. It overrides every other command and strobe in that cycle.
- R8: `media_write` fills all registers at the next clock edge. It overrides restore and the per-register strobes.
- R9: `restore_en` sets each register empty where its field in `restore_word` is 11, and full for any other field value. It overrides the per-register strobes.
- R10: `set_full[i]` fills register i and `set_empty[i]` empties it at the next edge. When both strobes are high, `set_empty[i]` wins. Registers with no strobe keep their state.
- R11: `tag_word` follows the register contents combinationally. A change to a full register's value changes its code without a clock edge, and the change leaves the occupancy bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_full | input | 8 | Per-register mark-full strobes |
| set_empty | input | 8 | Per-register mark-empty strobes |
| init_all | input | 1 | Empty all registers |
| media_write | input | 1 | Fill all registers |
| restore_en | input | 1 | Load occupancy from `restore_word` |
| restore_word | input | 16 | Saved tag word, 2 bits per register |
| reg_values | input | 640 | Register contents, register i in bits 80i+79:80i |
| tag_word | output | 16 | Architectural tag word |

## Verification
The assertions check the occupancy side of the block on every cycle. They cover the command priority, the per-register strobes, the rule that restore maps only 11 to empty, and the rule that occupancy holds when no command arrives. The bench scenarios are the only place that shows the classification of contents into valid, zero and special. They also show the exact field placement, the reset value, and the combinational response to a register value that changes between clock edges.

// File: rtl/fp_tag_tracker.sv
module fp_tag_tracker #(
  parameter int NREG = 8,
  parameter int EXPW = 15,
  parameter int SIGW = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG-1:0]               set_full,
  input  logic [NREG-1:0]               set_empty,
  input  logic                          init_all,
  input  logic                          media_write,
  input  logic                          restore_en,
  input  logic [2*NREG-1:0]             restore_word,
  input  logic [NREG*(1+EXPW+SIGW)-1:0] reg_values,
  output logic [2*NREG-1:0]             tag_word
);
  localparam int VW = 1 + EXPW + SIGW;

  logic [NREG-1:0] full_q, full_d;

  always_comb begin
    full_d = full_q;
    for (int i = 0; i < NREG; i++) begin
      if (set_empty[i])     full_d[i] = 1'b0;
      else if (set_full[i]) full_d[i] = 1'b1;
    end
    if (restore_en)
      for (int i = 0; i < NREG; i++)
        full_d[i] = (restore_word[2*i +: 2] != 2'b11);
    if (media_write) full_d = '1;
    if (init_all)    full_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;

  for (genvar g = 0; g < NREG; g++) begin : g_cls
    logic [EXPW-1:0] ex;
    logic [SIGW-1:0] sig;
    logic            special, zero;
    assign ex      = reg_values[g*VW + SIGW +: EXPW];
    assign sig     = reg_values[g*VW +: SIGW];
    assign zero    = (ex == '0) && (sig == '0);
    assign special = (&ex) || ((ex == '0) && (sig != '0)) ||
                     ((ex != '0) && !sig[SIGW-1]);
    assign tag_word[2*g +: 2] = !full_q[g] ? 2'b11 :
                                special    ? 2'b10 :
                                zero       ? 2'b01 : 2'b00;
  end
endmodule

// File: rtl/fp_tag_tracker_chk.sv
module fp_tag_tracker_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREG-1:0]   set_full,
  input logic [NREG-1:0]   set_empty,
  input logic              init_all,
  input logic              media_write,
  input logic              restore_en,
  input logic [2*NREG-1:0] restore_word,
  input logic [2*NREG-1:0] tag_word
);
  logic [NREG-1:0] emask, rmask;
  logic            glob;
  for (genvar g = 0; g < NREG; g++) begin : g_m
    assign emask[g] = &tag_word[2*g +: 2];
    assign rmask[g] = &restore_word[2*g +: 2];
  end
  assign glob = init_all | media_write | restore_en;

  a_r7_init_empties: assert property (@(posedge clk) disable iff (!rst_n)
    init_all |=> (emask == '1));
  a_r8_media_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (media_write && !init_all) |=> (emask == '0));
  a_r9_restore_map: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && !init_all && !media_write) |=> (emask == $past(rmask)));
  a_r10_strobe_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob && (|set_empty)) |=> (($past(set_empty) & ~emask) == '0));
  a_r10_strobe_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob && (|set_full)) |=> ((($past(set_full) & ~$past(set_empty)) & emask) == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob && set_full == '0 && set_empty == '0) |=> $stable(emask));
endmodule

bind fp_tag_tracker fp_tag_tracker_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_full(set_full), .set_empty(set_empty),
  .init_all(init_all), .media_write(media_write), .restore_en(restore_en),
  .restore_word(restore_word), .tag_word(tag_word));

// File: tb/tb_fp_tag_tracker.sv
module tb_fp_tag_tracker;
  localparam int PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] set_full = '0, set_empty = '0;
  logic init_all = 0, media_write = 0, restore_en = 0;
  logic [2*N-1:0] restore_word = '0;
  logic [N*80-1:0] vals = '0;
  logic [2*N-1:0] tag_word;
  logic [N-1:0] model_full = '0;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  fp_tag_tracker dut (.clk(clk), .rst_n(rst_n), .set_full(set_full), .set_empty(set_empty),
    .init_all(init_all), .media_write(media_write), .restore_en(restore_en),
    .restore_word(restore_word), .reg_values(vals), .tag_word(tag_word));

  function automatic logic [79:0] mk(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic logic [1:0] code_of(logic [79:0] v, bit f);
    logic [14:0] e = v[78:64];
    logic [63:0] m = v[63:0];
    if (!f) return 2'b11;
    if (e == 15'h7FFF) return 2'b10;
    if (e == 0) return (m == 0) ? 2'b01 : 2'b10;
    return m[63] ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [15:0] expect_word();
    logic [15:0] w;
    for (int i = 0; i < N; i++) w[2*i +: 2] = code_of(vals[i*80 +: 80], model_full[i]);
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    checks++;
    if (tag_word !== exp) begin
      errors++;
      $display("FAIL %s: tag_word=%h expected=%h", req, tag_word, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    set_full = '0; set_empty = '0; init_all = 0; media_write = 0; restore_en = 0;
  endtask

  task automatic t_reset();
    #1 chk("R1", 16'hFFFF);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1 chk("R1", 16'hFFFF);
    vals[0 +: 80] = mk(0, 15'h3FFF, 64'h8000_0000_0000_0000);
    #1 chk("R3", 16'hFFFF);
  endtask

  task automatic t_classify();
    vals[0*80 +: 80] = mk(0, 15'h0000, 64'h0);
    vals[1*80 +: 80] = mk(0, 15'h3FFF, 64'h8000_0000_0000_0000);
    vals[2*80 +: 80] = mk(1, 15'h7FFF, 64'h8000_0000_0000_0000);
    vals[3*80 +: 80] = mk(0, 15'h0000, 64'h0000_0000_0000_0001);
    vals[4*80 +: 80] = mk(0, 15'h0001, 64'h7FFF_FFFF_FFFF_FFFF);
    vals[5*80 +: 80] = mk(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    vals[6*80 +: 80] = mk(1, 15'h4001, 64'hA000_0000_0000_0000);
    vals[7*80 +: 80] = mk(0, 15'h0000, 64'h8000_0000_0000_0000);
    set_full = 8'hFF; model_full = 8'hFF;
    tick();
    chk("R2 R4 R5 R6", 16'h8AA1);
    chk("R4 R5 R6", expect_word());
  endtask

  task automatic t_comb();
    vals[1*80 +: 80] = mk(1, 15'h0, 64'h0);
    #1 chk("R11", expect_word());
    vals[4*80 +: 80] = mk(0, 15'h0001, 64'h8000_0000_0000_0000);
    #1 chk("R11 R6", expect_word());
  endtask

  task automatic t_strobes();
    set_empty = 8'b0000_1100; set_full = 8'b0000_0100;
    model_full = 8'b1111_0011;
    tick();
    chk("R10", expect_word());
    chk("R3", {tag_word[15:8], 2'b11, 2'b11, tag_word[3:0]});
    set_full = 8'b0000_1000;
    model_full = 8'b1111_1011;
    tick();
    chk("R10", expect_word());
    tick();
    chk("R10 hold", expect_word());
  endtask

  task automatic t_init();
    init_all = 1; media_write = 1; restore_en = 1; restore_word = '0; set_full = '1;
    model_full = '0;
    tick();
    chk("R7", 16'hFFFF);
  endtask

  task automatic t_media();
    media_write = 1; restore_en = 1; restore_word = '1; set_empty = '1;
    model_full = '1;
    tick();
    chk("R8", expect_word());
  endtask

  task automatic t_restore();
    restore_en = 1; restore_word = 16'b11_10_01_00_11_11_00_10; set_full = 8'hFF;
    model_full = 8'b0111_0011;
    tick();
    chk("R9", expect_word());
    restore_word = 16'hFFFF; restore_en = 1; model_full = '0;
    tick();
    chk("R9", 16'hFFFF);
  endtask

  initial begin
    #(PERIOD*5000);
    errors++; checks++;
    $display("FAIL watchdog: tag_word=%h expected=completion", tag_word);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_classify();
    t_comb();
    t_strobes();
    t_init();
    t_media();
    t_restore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule